// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table in memory. A requester hands over the virtual address, the kind of access (read, write or execute) and the byte address of the root table. The walker reads the root entry, which points to a second-level table. It then reads the leaf entry and checks the valid bit and the permission field. On success it returns the physical address and the leaf entry. On failure it returns a fault cause.

When an access is allowed, the walker also keeps the leaf entry's usage bits current. The accessed bit is set on every permitted access, and the dirty bit is set on every write. The updated entry is written back to memory, but only if one of those bits actually changed. That write completes before the response is given.

The walker serves one request at a time through a valid/ready handshake. It talks to memory through a simple request/acknowledge port. It holds no translations between requests.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address is split into a root index (bits 31:20), a leaf index (bits 19:12) and a page offset (bits 11:0). The root entry is read at root base + 4 × root index. The leaf entry is read at (root entry frame number × 4096) + 4 × leaf index.
- R2: Every table entry uses this layout: bit 0 valid, bit 1 accessed, bit 2 dirty, bits 4:3 permission, bits 31:12 frame number. Bits 11:5 are carried through unchanged.
- R3: If the root entry has its valid bit clear, the response carries fault code 1 and physical address 0, with the root entry as the returned entry. No second read is made.
- R4: If the leaf entry has its valid bit clear, the response carries fault code 2 and physical address 0, with the leaf entry returned unchanged.
- R5: Access codes are 0 read, 1 write, 2 execute, and 3, which is handled as a read. Permission codes are 00 read only, 01 read/write, 10 execute only, 11 read/write/execute. An access that a valid leaf entry's permission does not allow gives fault code 3 and physical address 0.
- R6: A permitted access gives fault code 0 and physical address = leaf frame number × 4096 + page offset.
- R7: On a permitted access the accessed bit is set, and on a write the dirty bit is also set. The entry is written back to the leaf address only if its value changed, and before the response. The response carries the updated entry. A fault never causes a write.
- R8: req_ready is high only while the walker is idle, and it drops for the cycle after a request is accepted. rsp_valid is a one-cycle pulse, and the walker is ready again in the next cycle.
- R9: mem_req stays high, with stable mem_addr, mem_we and mem_wdata, until mem_ack. mem_we is used only for the write-back. The response appears one cycle after the last memory acknowledge.
- R10: After reset, req_ready is 1, and rsp_valid and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| req_root | input | 32 | Byte address of the root table |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_pte | output | 32 | Final entry: updated leaf on success, faulting entry otherwise |
| rsp_fault | output | 2 | 0 none, 1 root invalid, 2 leaf invalid, 3 permission |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (entry write-back) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
Requests are run against a sparse memory image. The image holds valid and invalid root entries, invalid leaf entries, and leaf pages with each of the four permission codes, each tried with every access kind. Comparing a repeated read with a first read of the same page shows whether the write-back is suppressed when the usage bits do not change. A write that follows a read shows the dirty bit being added on its own. Root and leaf indices at their maximum values, a second root base, and memory latencies of zero and several stall cycles separate correct address arithmetic and handshake holding from errors that only show up at one index width or one latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int SIDX_W = 8;
  localparam int PTE_W  = 32;

  localparam int PTE_V    = 0;
  localparam int PTE_R    = 1;
  localparam int PTE_M    = 2;
  localparam int PTE_P_LO = 3;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    PROT_RO  = 2'd0,
    PROT_RW  = 2'd1,
    PROT_XO  = 2'd2,
    PROT_RWX = 2'd3
  } prot_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ROOT   = 2'd1,
    FLT_LEAF   = 2'd2,
    FLT_PERM   = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD_ROOT = 3'd1,
    ST_RD_LEAF = 3'd2,
    ST_WB   = 3'd3,
    ST_RESP = 3'd4
  } wstate_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int SIDX_W = 8,
  parameter int ENT_SH = 2
) (
  input  logic [VA_W-1:0]       vaddr,
  input  logic [VA_W-1:0]       root_base,
  input  logic [VA_W-OFF_W-1:0] leaf_pfn,
  output logic [VA_W-1:0]       root_addr,
  output logic [VA_W-1:0]       leaf_addr,
  output logic [OFF_W-1:0]      page_off
);
  localparam int MIDX_W = VA_W - OFF_W - SIDX_W;
  localparam int PFN_W  = VA_W - OFF_W;

  logic [MIDX_W-1:0] root_idx;
  logic [SIDX_W-1:0] leaf_idx;

  assign root_idx = vaddr[VA_W-1 -: MIDX_W];
  assign leaf_idx = vaddr[OFF_W +: SIDX_W];
  assign page_off = vaddr[OFF_W-1:0];

  // Entry offsets are index scaled by entry size
  assign root_addr = root_base +
    {{(VA_W-MIDX_W-ENT_SH){1'b0}}, root_idx, {ENT_SH{1'b0}}};
  assign leaf_addr = {leaf_pfn[PFN_W-1:0], {OFF_W{1'b0}}} +
    {{(VA_W-SIDX_W-ENT_SH){1'b0}}, leaf_idx, {ENT_SH{1'b0}}};
endmodule

// File: rtl/ptw_access_check.sv
module ptw_access_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       access,
  output logic             entry_valid,
  output logic             allowed,
  output logic [PTE_W-1:0] pte_upd,
  output logic             needs_wb
);
  prot_e prot;
  acc_e  acc;
  logic  is_rd, is_wr, is_ex;

  assign prot  = prot_e'(pte[PTE_P_LO +: 2]);
  assign acc   = acc_e'(access);
  assign is_wr = (acc == ACC_WR);
  assign is_ex = (acc == ACC_EX);
  assign is_rd = (acc == ACC_RD) || (acc == ACC_RSV);
  assign entry_valid = pte[PTE_V];

  always_comb begin
    unique case (prot)
      PROT_RO:  allowed = is_rd;
      PROT_RW:  allowed = is_rd || is_wr;
      PROT_XO:  allowed = is_ex;
      PROT_RWX: allowed = 1'b1;
      default:  allowed = 1'b0;
    endcase
  end

  always_comb begin
    pte_upd        = pte;
    pte_upd[PTE_R] = 1'b1;
    if (is_wr) pte_upd[PTE_M] = 1'b1;
  end

  assign needs_wb = (pte_upd != pte);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W   = ptw_pkg::VA_W,
  parameter int OFF_W  = ptw_pkg::OFF_W,
  parameter int SIDX_W = ptw_pkg::SIDX_W,
  parameter int PTE_W  = ptw_pkg::PTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_access,
  input  logic [VA_W-1:0]  req_root,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic [PTE_W-1:0] rsp_pte,
  output logic [1:0]       rsp_fault,
  output logic             mem_req,
  output logic             mem_we,
  output logic [VA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic [PTE_W-1:0] mem_rdata,
  input  logic             mem_ack
);
  localparam int PFN_W  = PTE_W - OFF_W;
  localparam int ENT_SH = $clog2(PTE_W / 8);

  wstate_e          state_q, state_d;
  logic [VA_W-1:0]  va_q, root_q;
  logic [1:0]       acc_q;
  logic [PFN_W-1:0] leaf_pfn_q;
  logic [PTE_W-1:0] pte_q, pte_d;
  fault_e           fault_q, fault_d;

  logic accept, root_done, leaf_done;
  logic req_en, pfn_en, pte_en, fault_en;

  logic [VA_W-1:0]  root_addr, leaf_addr;
  logic [OFF_W-1:0] page_off;
  logic             chk_valid, chk_allowed, chk_wb;
  logic [PTE_W-1:0] chk_upd;

  ptw_addr_gen #(
    .VA_W(VA_W), .OFF_W(OFF_W), .SIDX_W(SIDX_W), .ENT_SH(ENT_SH)
  ) u_addr (
    .vaddr(va_q),
    .root_base(root_q),
    .leaf_pfn(leaf_pfn_q),
    .root_addr(root_addr),
    .leaf_addr(leaf_addr),
    .page_off(page_off)
  );

  ptw_access_check #(.PTE_W(PTE_W)) u_chk (
    .pte(mem_rdata),
    .access(acc_q),
    .entry_valid(chk_valid),
    .allowed(chk_allowed),
    .pte_upd(chk_upd),
    .needs_wb(chk_wb)
  );

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign root_done = (state_q == ST_RD_ROOT) && mem_ack;
  assign leaf_done = (state_q == ST_RD_LEAF) && mem_ack;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_RD_ROOT;
      ST_RD_ROOT: if (mem_ack) state_d = mem_rdata[PTE_V] ? ST_RD_LEAF : ST_RESP;
      ST_RD_LEAF: if (mem_ack) begin
        if (chk_valid && chk_allowed && chk_wb) state_d = ST_WB;
        else                                    state_d = ST_RESP;
      end
      ST_WB:      if (mem_ack) state_d = ST_RESP;
      ST_RESP:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // Clock enables and datapath next values
  assign req_en   = accept;
  assign pfn_en   = root_done;
  assign pte_en   = (root_done && !mem_rdata[PTE_V]) || leaf_done;
  assign fault_en = accept || root_done || leaf_done;

  always_comb begin
    if (leaf_done && chk_valid && chk_allowed) pte_d = chk_upd;
    else                                       pte_d = mem_rdata;
  end

  always_comb begin
    fault_d = FLT_NONE;
    if (root_done && !mem_rdata[PTE_V]) fault_d = FLT_ROOT;
    else if (leaf_done) begin
      if (!chk_valid)        fault_d = FLT_LEAF;
      else if (!chk_allowed) fault_d = FLT_PERM;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      root_q     <= '0;
      acc_q      <= '0;
      leaf_pfn_q <= '0;
      pte_q      <= '0;
      fault_q    <= FLT_NONE;
    end else begin
      state_q <= state_d;
      if (req_en) begin
        va_q   <= req_vaddr;
        root_q <= req_root;
        acc_q  <= req_access;
      end
      if (pfn_en)   leaf_pfn_q <= mem_rdata[PTE_W-1 -: PFN_W];
      if (pte_en)   pte_q      <= pte_d;
      if (fault_en) fault_q    <= fault_d;
    end
  end

  // Outputs
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_fault = rsp_valid ? fault_q : FLT_NONE;
  assign rsp_pte   = rsp_valid ? pte_q : '0;
  assign rsp_paddr = (rsp_valid && fault_q == FLT_NONE) ?
                     {pte_q[PTE_W-1 -: PFN_W], page_off} : '0;

  assign mem_req   = (state_q == ST_RD_ROOT) || (state_q == ST_RD_LEAF) ||
                     (state_q == ST_WB);
  assign mem_we    = (state_q == ST_WB);
  assign mem_addr  = (state_q == ST_RD_ROOT) ? root_addr : leaf_addr;
  assign mem_wdata = (state_q == ST_WB) ? pte_q : '0;

  // Assertions
  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));

  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R3, R4, R5: faults never yield an address
  a_r3_fault_no_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0);

  a_r7_wb_marks_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[PTE_R] && mem_wdata[PTE_V]);

  a_r6_ok_entry_marked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'd0 |-> rsp_pte[PTE_V] && rsp_pte[PTE_R]);

  a_r9_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr, req_root;
  logic [1:0]  req_access;
  logic        rsp_valid;
  logic [31:0] rsp_paddr, rsp_pte;
  logic [1:0]  rsp_fault;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lat = 0;
  int stall = 0;
  int txn_cnt = 0;
  int wr_cnt = 0;
  int due = 0;
  bit pending = 0;
  bit done = 0;

  logic [31:0] mem [logic [31:0]];

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_access(req_access), .req_root(req_root),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_pte(rsp_pte),
    .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // Memory responder with programmable stall
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 32'h0;
      stall = 0;
    end else if (mem_req && !mem_ack) begin
      if (stall >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= rd(mem_addr);
        txn_cnt = txn_cnt + 1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt = wr_cnt + 1;
        end
        stall = 0;
      end else begin
        stall = stall + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison of the response strobe (R8, R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9", "rsp_valid timing", {31'b0, rsp_valid},
            {31'b0, (pending && cyc == due)});
    end
  end

  // Behavioural reference model from the requirements
  task automatic model(input logic [31:0] va, input logic [1:0] acc,
                       input logic [31:0] root,
                       output logic [1:0] f, output logic [31:0] pa,
                       output logic [31:0] pte, output int n,
                       output logic [31:0] wa, output logic [31:0] wv);
    logic [31:0] m, p, nv;
    bit ok;
    m = rd(root + {18'b0, va[31:20], 2'b00});
    wa = 32'h0; wv = 32'h0;
    if (!m[0]) begin
      f = 2'd1; pa = 32'h0; pte = m; n = 1;
      return;
    end
    wa = {m[31:12], 12'h000} + {22'b0, va[19:12], 2'b00};
    p  = rd(wa);
    wv = p;
    if (!p[0]) begin
      f = 2'd2; pa = 32'h0; pte = p; n = 2;
      return;
    end
    case (p[4:3])
      2'd0: ok = (acc == 2'd0) || (acc == 2'd3);
      2'd1: ok = (acc != 2'd2);
      2'd2: ok = (acc == 2'd2);
      default: ok = 1'b1;
    endcase
    if (!ok) begin
      f = 2'd3; pa = 32'h0; pte = p; n = 2;
      return;
    end
    nv = p | 32'h2 | ((acc == 2'd1) ? 32'h4 : 32'h0);
    n  = (nv != p) ? 3 : 2;
    f  = 2'd0;
    pa = {p[31:12], va[11:0]};
    pte = nv;
    wv = nv;
  endtask

  task automatic walk(input string tag, input logic [31:0] va,
                      input logic [1:0] acc, input logic [31:0] root);
    logic [1:0]  ef;
    logic [31:0] epa, epte, ewa, ewv;
    int en, t0, w0, guard;
    model(va, acc, root, ef, epa, epte, en, ewa, ewv);
    @(negedge clk);
    check("R8", "ready before request", {31'b0, req_ready}, 32'h1);
    req_valid  = 1'b1;
    req_vaddr  = va;
    req_access = acc;
    req_root   = root;
    t0 = txn_cnt;
    w0 = wr_cnt;
    due = cyc + 1 + en * (lat + 2);
    pending = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8", "ready drops after accept", {31'b0, req_ready}, 32'h0);
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(tag, "fault", {30'b0, rsp_fault}, {30'b0, ef});
    check(tag, "paddr", rsp_paddr, epa);
    check(tag, "pte", rsp_pte, epte);
    check("R1", "memory accesses", t0 == 0 ? txn_cnt : txn_cnt - t0, en);
    check("R7", "write-backs", wr_cnt - w0, (en == 3) ? 1 : 0);
    if (ewa != 32'h0) check("R7", "memory entry after", rd(ewa), ewv);
    @(negedge clk);
    pending = 1'b0;
    check("R8", "ready after response", {31'b0, req_ready}, 32'h1);
  endtask

  localparam logic [31:0] ROOT_A = 32'h0001_0000;
  localparam logic [31:0] ROOT_B = 32'h0002_0400;

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_access = '0; req_root = '0;
    // Root entries (R1, R2): frame number points to leaf table
    mem[ROOT_A + 32'h00C]  = 32'h0004_0001;   // index 0x003 -> leaf at 0x40000
    mem[ROOT_A + 32'h3FFC] = 32'h0005_0001;   // index 0xFFF -> leaf at 0x50000
    mem[ROOT_A + 32'h010]  = 32'h0006_0F00;   // index 0x004 invalid, junk bits
    mem[ROOT_B + 32'h00C]  = 32'h0007_0001;   // second root table
    // Leaf entries
    mem[32'h0004_0048] = 32'h1234_5009;   // 0x12: RW
    mem[32'h0004_0050] = 32'hABCD_E001;   // 0x14: RO
    mem[32'h0004_0054] = 32'h0BEE_F011;   // 0x15: XO
    mem[32'h0004_0058] = 32'h0CAF_E01B;   // 0x16: RWX, accessed
    mem[32'h0004_004C] = 32'h7777_7FE0;   // 0x13: invalid
    mem[32'h0005_03FC] = 32'hFEDC_B019;   // index 0xFF: RWX
    mem[32'h0007_0048] = 32'h0001_1001;   // second table, RO
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "req_ready after reset", {31'b0, req_ready}, 32'h1);
    check("R10", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    check("R10", "mem_req after reset", {31'b0, mem_req}, 32'h0);

    lat = 0;
    walk("R6", 32'h0031_2ABC, 2'd0, ROOT_A);   // first read sets accessed
    walk("R7", 32'h0031_2ABC, 2'd0, ROOT_A);   // no change, no write
    walk("R7", 32'h0031_2004, 2'd1, ROOT_A);   // write adds dirty
    walk("R3", 32'h7FF0_0123, 2'd0, ROOT_A);   // missing root entry
    walk("R3", 32'h0041_2000, 2'd2, ROOT_A);   // invalid root with junk
    walk("R4", 32'h0031_3FFF, 2'd1, ROOT_A);   // invalid leaf
    lat = 3;
    walk("R5", 32'h0031_4010, 2'd1, ROOT_A);   // write to RO
    walk("R5", 32'h0031_4010, 2'd2, ROOT_A);   // execute on RO
    walk("R6", 32'h0031_4010, 2'd3, ROOT_A);   // code 3 read on RO
    walk("R5", 32'h0031_5020, 2'd0, ROOT_A);   // read on XO
    walk("R5", 32'h0031_5020, 2'd3, ROOT_A);   // code 3 on XO
    walk("R6", 32'h0031_5020, 2'd2, ROOT_A);   // execute on XO
    lat = 1;
    walk("R7", 32'h0031_6FFC, 2'd1, ROOT_A);   // RWX write
    walk("R6", 32'h0031_6000, 2'd2, ROOT_A);   // RWX execute, no change
    walk("R1", 32'hFFFF_F123, 2'd0, ROOT_A);   // max indices
    walk("R1", 32'h0031_2777, 2'd0, ROOT_B);   // other root base
    walk("R5", 32'h0031_2777, 2'd1, ROOT_B);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule